// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one control-transfer operation per cycle. From a test operand, a condition selector, the current program counter, a word displacement and a register-held target, it decides whether control moves, works out the address of the next instruction, and produces a return address together with its write strobe. Addresses are plain 64-bit values. No segmentation or translation is applied to them.

Three forms of transfer are supported, plus a "none" form. A conditional branch tests the operand for zero, for its sign, for a combination of the two, or for the parity of its lowest bit. It then moves to a PC-relative target. An unconditional branch always moves to the PC-relative target and writes the return address. A register jump moves to the register target with its two lowest bits cleared, and it also writes the return address. All results pass through one register stage. A two-state controller (`ST_IDLE`, `ST_VALID`) tracks whether that stage holds a fresh result. Its transitions are: IDLE to VALID on `in_valid`, VALID to VALID on `in_valid`, VALID to IDLE on no `in_valid`, and IDLE to IDLE on no `in_valid`. Synchronous reset forces IDLE.

Top module: `bcu_branch_unit`

## Requirements
- R1: With `kind`=0 (conditional), `cond`=0 (EQ) is taken when the operand is zero, and `cond`=1 (NE) is taken when it is nonzero.
- R2: `cond`=2 (LT) is taken when operand bit 63 is 1. `cond`=3 (GE) is taken when bit 63 is 0.
- R3: `cond`=4 (LE) is taken when the operand is negative or zero. `cond`=5 (GT) is taken when it is positive and nonzero.
- R4: `cond`=6 (low bit clear) is taken when operand bit 0 is 0. `cond`=7 (low bit set) is taken when bit 0 is 1. No other operand bit matters.
- R5: A taken conditional branch gives next PC = PC + 4 + 4 × sign-extended `disp`, computed modulo 2^64.
- R6: A conditional branch that is not taken gives next PC = PC + 4. Conditional branches never assert the link strobe.
- R7: With `kind`=1 (unconditional), the transfer is always taken to the PC-relative target, `out_link_we`=1, and `out_link` = PC + 4.
- R8: With `kind`=2 (register jump), the transfer is taken to `jmp_target` with bits [1:0] forced to 0, `out_link_we`=1, and `out_link` = PC + 4.
- R9: With `kind`=3 (none), the result is not taken, next PC = PC + 4, and `out_link_we`=0.
- R10: `out_valid` equals `in_valid` from the previous clock edge. Synchronous reset clears `out_valid`.
- R11: A cycle without `in_valid` leaves `out_taken`, `out_next_pc`, `out_link` and `out_link_we` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| kind | input | 2 | 0 conditional, 1 unconditional, 2 register jump, 3 none |
| cond | input | 3 | Condition selector (see R1–R4) |
| opnd | input | 64 | Test operand |
| pc | input | 64 | Address of the current instruction |
| disp | input | DISP_W (21) | Signed word displacement |
| jmp_target | input | 64 | Register-held jump address |
| out_valid | output | 1 | Registered result present |
| out_taken | output | 1 | Transfer taken |
| out_next_pc | output | 64 | Address of the next instruction |
| out_link | output | 64 | Return address |
| out_link_we | output | 1 | Write strobe for the return address |

## Verification
Each request surfaces at the ports exactly one edge after it is presented. A wrong controller state therefore shows up on the very next cycle, either as a valid pulse that is missing or extra, or as result data that drifts during an idle cycle. A wrong condition or target shows up in `out_taken` or `out_next_pc` in that same cycle. The stimulus concentrates on the places where such faults hide: zero and sign-boundary operands, single-bit parity operands, negative displacements, PC wraparound, and jump targets with their low bits set.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    typedef enum logic [1:0] {
        K_COND   = 2'd0,
        K_UNCOND = 2'd1,
        K_JUMP   = 2'd2,
        K_NONE   = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        C_EQ  = 3'd0,
        C_NE  = 3'd1,
        C_LT  = 3'd2,
        C_GE  = 3'd3,
        C_LE  = 3'd4,
        C_GT  = 3'd5,
        C_LBC = 3'd6,
        C_LBS = 3'd7
    } cond_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } stage_st_e;
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval #(
    parameter int DATA_W = 64
) (
    input  logic [2:0]        cond,
    input  logic [DATA_W-1:0] opnd,
    output logic              hit
);
    import bcu_pkg::*;

    logic is_zero;
    logic is_neg;
    logic is_odd;

    assign is_zero = (opnd == '0);
    assign is_neg  = opnd[DATA_W-1];
    assign is_odd  = opnd[0];

    always_comb begin
        unique case (cond_e'(cond))
            C_EQ:    hit = is_zero;
            C_NE:    hit = !is_zero;
            C_LT:    hit = is_neg;
            C_GE:    hit = !is_neg;
            C_LE:    hit = is_neg || is_zero;
            C_GT:    hit = !is_neg && !is_zero;
            C_LBC:   hit = !is_odd;
            C_LBS:   hit = is_odd;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcu_target_gen.sv
module bcu_target_gen #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 21
) (
    input  logic [1:0]        kind,
    input  logic              hit,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] jmp_target,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] link,
    output logic              link_we
);
    import bcu_pkg::*;

    localparam int EXT_W = ADDR_W - DISP_W - 2;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] byte_off;
    logic [ADDR_W-1:0] rel_pc;
    logic [ADDR_W-1:0] abs_pc;

    assign seq_pc   = pc + ADDR_W'(4);
    assign byte_off = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    assign rel_pc   = seq_pc + byte_off;
    assign abs_pc   = {jmp_target[ADDR_W-1:2], 2'b00};
    assign link     = seq_pc;

    always_comb begin
        unique case (kind_e'(kind))
            K_COND: begin
                taken   = hit;
                next_pc = hit ? rel_pc : seq_pc;
                link_we = 1'b0;
            end
            K_UNCOND: begin
                taken   = 1'b1;
                next_pc = rel_pc;
                link_we = 1'b1;
            end
            K_JUMP: begin
                taken   = 1'b1;
                next_pc = abs_pc;
                link_we = 1'b1;
            end
            default: begin
                taken   = 1'b0;
                next_pc = seq_pc;
                link_we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bcu_out_stage.sv
module bcu_out_stage #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              d_taken,
    input  logic [ADDR_W-1:0] d_next_pc,
    input  logic [ADDR_W-1:0] d_link,
    input  logic              d_link_we,
    output logic              out_valid,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_next_pc,
    output logic [ADDR_W-1:0] out_link,
    output logic              out_link_we
);
    import bcu_pkg::*;

    stage_st_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_taken   <= 1'b0;
            out_next_pc <= '0;
            out_link    <= '0;
            out_link_we <= 1'b0;
        end else if (in_valid) begin
            out_taken   <= d_taken;
            out_next_pc <= d_next_pc;
            out_link    <= d_link;
            out_link_we <= d_link_we;
        end
    end

    assign out_valid = (state_q == ST_VALID);

    // R10
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !out_valid);
    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_next_pc) && $stable(out_link)
                       && $stable(out_taken) && $stable(out_link_we)));
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        kind,
    input  logic [2:0]        cond,
    input  logic [ADDR_W-1:0] opnd,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] jmp_target,
    output logic              out_valid,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_next_pc,
    output logic [ADDR_W-1:0] out_link,
    output logic              out_link_we
);
    import bcu_pkg::*;

    logic              hit;
    logic              c_taken;
    logic [ADDR_W-1:0] c_next_pc;
    logic [ADDR_W-1:0] c_link;
    logic              c_link_we;

    bcu_cond_eval #(.DATA_W(ADDR_W)) u_cond (
        .cond (cond),
        .opnd (opnd),
        .hit  (hit)
    );

    bcu_target_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .kind       (kind),
        .hit        (hit),
        .pc         (pc),
        .disp       (disp),
        .jmp_target (jmp_target),
        .taken      (c_taken),
        .next_pc    (c_next_pc),
        .link       (c_link),
        .link_we    (c_link_we)
    );

    bcu_out_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .d_taken     (c_taken),
        .d_next_pc   (c_next_pc),
        .d_link      (c_link),
        .d_link_we   (c_link_we),
        .out_valid   (out_valid),
        .out_taken   (out_taken),
        .out_next_pc (out_next_pc),
        .out_link    (out_link),
        .out_link_we (out_link_we)
    );

    // R7
    link_implies_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_link_we) |-> out_taken);
    // R8
    jump_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(kind) == 2'd2) |-> (out_next_pc[1:0] == 2'b00));
    // R9
    none_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(kind) == 2'd3) |-> (!out_taken && !out_link_we));
endmodule

// File: tb/bcu_branch_unit_tb.sv
module bcu_branch_unit_tb;
    localparam int AW = 64;
    localparam int DW = 21;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    kind;
    logic [2:0]    cond;
    logic [AW-1:0] opnd;
    logic [AW-1:0] pc;
    logic [DW-1:0] disp;
    logic [AW-1:0] jmp_target;
    logic          out_valid;
    logic          out_taken;
    logic [AW-1:0] out_next_pc;
    logic [AW-1:0] out_link;
    logic          out_link_we;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    bcu_branch_unit #(.ADDR_W(AW), .DISP_W(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .cond(cond),
        .opnd(opnd), .pc(pc), .disp(disp), .jmp_target(jmp_target),
        .out_valid(out_valid), .out_taken(out_taken), .out_next_pc(out_next_pc),
        .out_link(out_link), .out_link_we(out_link_we)
    );

    function automatic logic exp_hit(input logic [2:0] c, input logic [AW-1:0] v);
        case (c)
            3'd0: return v == 0;
            3'd1: return v != 0;
            3'd2: return v[AW-1];
            3'd3: return !v[AW-1];
            3'd4: return v[AW-1] || v == 0;
            3'd5: return !v[AW-1] && v != 0;
            3'd6: return !v[0];
            default: return v[0];
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_rel(input logic [AW-1:0] p, input logic [DW-1:0] d);
        longint signed sd;
        sd = longint'(signed'(d));
        return p + 64'd4 + (sd * 4);
    endfunction

    function automatic logic exp_taken(input logic [1:0] k, input logic [2:0] c, input logic [AW-1:0] v);
        if (k == 2'd0) return exp_hit(c, v);
        return k == 2'd1 || k == 2'd2;
    endfunction

    function automatic logic [AW-1:0] exp_next(input logic [1:0] k, input logic [2:0] c,
        input logic [AW-1:0] v, input logic [AW-1:0] p, input logic [DW-1:0] d, input logic [AW-1:0] t);
        if (k == 2'd2) return t & ~64'd3;
        if (k == 2'd1 || (k == 2'd0 && exp_hit(c, v))) return exp_rel(p, d);
        return p + 64'd4;
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input string tag, input logic [1:0] k, input logic [2:0] c,
        input logic [AW-1:0] v, input logic [AW-1:0] p, input logic [DW-1:0] d, input logic [AW-1:0] t);
        in_valid = 1'b1; kind = k; cond = c; opnd = v; pc = p; disp = d; jmp_target = t;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R10 valid"}, 64'(out_valid), 64'd1);
        chk({tag, " taken"}, 64'(out_taken), 64'(exp_taken(k, c, v)));
        chk({tag, " next_pc"}, out_next_pc, exp_next(k, c, v, p, d, t));
        chk({tag, " link_we"}, 64'(out_link_we), 64'(k == 2'd1 || k == 2'd2));
        if (k == 2'd1 || k == 2'd2)
            chk({tag, " link"}, out_link, p + 64'd4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] hn, hl;
        logic          ht, hw;
        void'($urandom(32'd7321));
        rst = 1'b1; in_valid = 1'b0; kind = 0; cond = 0; opnd = 0; pc = 0; disp = 0; jmp_target = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 idle after reset", 64'(out_valid), 64'd0);

        run_one("R1 EQ zero",     2'd0, 3'd0, 64'd0, 64'h1000, 21'd5, 64'd0);
        run_one("R1 EQ nonzero",  2'd0, 3'd0, 64'd1, 64'h1000, 21'd5, 64'd0);
        run_one("R1 NE zero",     2'd0, 3'd1, 64'd0, 64'h2000, 21'd9, 64'd0);
        run_one("R1 NE big",      2'd0, 3'd1, 64'h8000_0000_0000_0000, 64'h2000, 21'd9, 64'd0);
        run_one("R2 LT min",      2'd0, 3'd2, 64'h8000_0000_0000_0000, 64'h40, 21'h1FFFFF, 64'd0);
        run_one("R2 GE zero",     2'd0, 3'd3, 64'd0, 64'h40, 21'h1FFFFF, 64'd0);
        run_one("R2 GE max",      2'd0, 3'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h40, 21'd1, 64'd0);
        run_one("R3 LE zero",     2'd0, 3'd4, 64'd0, 64'h80, 21'd3, 64'd0);
        run_one("R3 LE one",      2'd0, 3'd4, 64'd1, 64'h80, 21'd3, 64'd0);
        run_one("R3 GT zero",     2'd0, 3'd5, 64'd0, 64'h80, 21'd3, 64'd0);
        run_one("R3 GT one",      2'd0, 3'd5, 64'd1, 64'h80, 21'd3, 64'd0);
        run_one("R3 GT neg",      2'd0, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h80, 21'd3, 64'd0);
        run_one("R4 LBC even",    2'd0, 3'd6, 64'hFFFF_FFFF_FFFF_FFFE, 64'h100, 21'd2, 64'd0);
        run_one("R4 LBS odd",     2'd0, 3'd7, 64'h1, 64'h100, 21'd2, 64'd0);
        run_one("R4 LBS even",    2'd0, 3'd7, 64'h8000_0000_0000_0002, 64'h100, 21'd2, 64'd0);
        run_one("R5 back min",    2'd0, 3'd0, 64'd0, 64'h0040_0000, 21'h100000, 64'd0);
        run_one("R5 wrap",        2'd0, 3'd1, 64'd7, 64'hFFFF_FFFF_FFFF_FFFC, 21'd1, 64'd0);
        run_one("R6 not taken",   2'd0, 3'd2, 64'd5, 64'h300, 21'd100, 64'd0);
        run_one("R7 uncond",      2'd1, 3'd0, 64'd9, 64'h500, 21'h1FFFF0, 64'd0);
        run_one("R8 jump low3",   2'd2, 3'd0, 64'd9, 64'h600, 21'd0, 64'h1234_5678_9ABC_DEF3);
        run_one("R9 none",        2'd3, 3'd1, 64'd9, 64'h700, 21'd44, 64'hFFFF);

        // R11: idle cycle holds result, R10 drops valid
        ht = out_taken; hn = out_next_pc; hl = out_link; hw = out_link_we;
        in_valid = 1'b0; kind = 2'd1; pc = 64'hDEAD; opnd = 64'd0;
        @(posedge clk); @(negedge clk);
        chk("R10 valid drop", 64'(out_valid), 64'd0);
        chk("R11 hold next_pc", out_next_pc, hn);
        chk("R11 hold link", out_link, hl);
        chk("R11 hold taken", 64'({out_taken, out_link_we}), 64'({ht, hw}));

        for (int i = 0; i < 400; i++) begin
            logic [1:0]    rk;
            logic [2:0]    rc;
            logic [AW-1:0] rv;
            rk = 2'($urandom());
            rc = 3'($urandom());
            case ($urandom() % 4)
                0: rv = 64'd0;
                1: rv = 64'($urandom() % 4);
                default: rv = {$urandom(), $urandom()};
            endcase
            run_one("R5 rand", rk, rc, rv, {$urandom(), $urandom()}, DW'($urandom()),
                    {$urandom(), $urandom()});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule